// File: doc/BRIEF.md
# Health-Gated Multi-Lane Entropy Collector

This block gathers raw randomness from several independent entropy lanes and delivers one parallel random word per sample. Each lane receives the full sampled state vector of its free-running oscillator group, which is asynchronous to the system clock. The vector passes through a two-flop synchronizer and is folded by XOR into a single bit. A sample-enable pulse sets the sampling rate as a fraction of the system clock, and each pulse yields one bit per lane. Throughput therefore scales linearly with the lane count.

Every lane runs two online health tests on its own bit stream. The first is a run-length (repetition) test. The second is a windowed proportion-of-ones test. A lane that fails either test has its output bit forced to 0 and its mask bit cleared, and its error flag is raised. The lane returns to normal service by itself once its tests pass again. A global error output is the OR of the per-lane flags.

The output side is a valid-only stream. `out_valid` pulses for one cycle per accepted sample, and there is no ready input. A consumer that cannot take a word loses it, because the block never stalls or buffers. Lanes whose mask bit is 0 in that word must be discarded by the consumer.

Top module: `entropy_collector`

## Requirements
- R1: The lane count `NUM_LANES` is a parameter restricted to 1, 2, 4 or 8.
- R2: For every lane that passes its tests, the output bit is the XOR (odd parity) of all `STATE_W` bits of that lane's sampled oscillator state.
- R3: Each oscillator input goes through two synchronizer flops. The state must be held stable for two clock cycles before `sample_en` is high. `out_valid` then pulses exactly two cycles after the cycle in which `sample_en` is high.
- R4: While `sample_en` is low, `out_valid` stays 0 and `out_data`, `out_mask` and `lane_err` do not change, whatever the oscillator inputs do.
- R5: Repetition test: when a lane has produced `RCT_LIMIT` (default 8) identical bits in a row, that sample and every further identical sample are masked, and the lane's error flag is 1.
- R6: The first sample that differs from the failing run clears the repetition failure, and that sample is delivered unmasked.
- R7: Proportion test: samples are grouped into consecutive windows of `APT_WIN` (default 64) samples counted from reset. If the number of ones in a window is below `APT_LO` (default 16) or above `APT_HI` (default 48), the sample that closes the window is masked. The lane then stays masked with its error flag set through the whole next window.
- R8: The proportion bounds are inclusive: a window holding exactly `APT_HI` ones passes.
- R9: A proportion failure clears at the close of the next window whose count is inside the bounds, and that closing sample is delivered unmasked.
- R10: A masked lane outputs `out_data` bit 0 and `out_mask` bit 0. `err_any` is 1 exactly when any `lane_err` bit is 1.
- R11: After reset `out_valid`, `out_data`, `out_mask`, `lane_err` and `err_any` are all 0.
- R12: Lanes are independent: a failing lane does not mask or alter the data of any other lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Take one sample in this cycle |
| osc_state | input | NUM_LANES*STATE_W | Raw oscillator states, lane i at bits [i*STATE_W +: STATE_W] |
| out_valid | output | 1 | One-cycle pulse: a new word is on out_data |
| out_data | output | NUM_LANES | Random bits, one per lane, 0 where masked |
| out_mask | output | NUM_LANES | 1 where the lane's bit is healthy |
| lane_err | output | NUM_LANES | Per-lane health failure flag |
| err_any | output | 1 | OR of all lane_err bits |

## Verification
The hardest state to reach from the ports is a proportion failure that is not also a repetition failure. The bias has to build up over a whole 64-sample window while no run ever reaches eight. Recovering from it then takes a second full window with a balanced count. The stimulus reaches this state with periodic patterns of period seven (six ones and a zero, or the reverse), which give 55 or 9 ones per window with runs of at most six. A period-four pattern lands exactly on the upper bound. Every pattern is driven as whole state vectors whose parity carries the intended bit, so the XOR fold and the synchronizer sit inside every test.

// File: rtl/ec_pkg.sv
package ec_pkg;
  // Legal lane counts for the collector.
  function automatic bit lanes_legal(input int n);
    return (n == 1) || (n == 2) || (n == 4) || (n == 8);
  endfunction

  // Width needed to hold values 0..n.
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ec_sync.sv
module ec_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/ec_rct.sv
module ec_rct #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic bit_i,
  output logic fail_nx_o,
  output logic fail_q_o
);
  localparam int CW = ec_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          last_q;
  logic          seen_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;
  logic          fail_q;

  always_comb begin
    if (seen_q && (bit_i == last_q))
      run_nx = (run_q == LIM) ? run_q : run_q + 1'b1;
    else
      run_nx = CW'(1);
  end

  assign fail_nx_o = (run_nx >= LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
      fail_q <= 1'b0;
    end else if (upd_i) begin
      last_q <= bit_i;
      seen_q <= 1'b1;
      run_q  <= run_nx;
      fail_q <= fail_nx_o;
    end
  end

  assign fail_q_o = fail_q;
endmodule

// File: rtl/ec_apt.sv
module ec_apt #(
  parameter int WIN = 64,
  parameter int LO  = 16,
  parameter int HI  = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic bit_i,
  output logic fail_nx_o,
  output logic fail_q_o
);
  localparam int IW = (WIN < 2) ? 1 : $clog2(WIN);
  localparam int OW = ec_pkg::cnt_width(WIN);
  localparam logic [IW-1:0] LAST_IDX = IW'(WIN - 1);
  localparam logic [OW-1:0] LO_V = OW'(LO);
  localparam logic [OW-1:0] HI_V = OW'(HI);

  logic [IW-1:0] idx_q;
  logic [OW-1:0] ones_q;
  logic [OW-1:0] ones_nx;
  logic          win_end;
  logic          out_range;
  logic          fail_q;

  assign ones_nx   = ones_q + OW'(bit_i);
  assign win_end   = (idx_q == LAST_IDX);
  assign out_range = (ones_nx < LO_V) || (ones_nx > HI_V);
  assign fail_nx_o = win_end ? out_range : fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ones_q <= '0;
      fail_q <= 1'b0;
    end else if (upd_i) begin
      idx_q  <= win_end ? '0 : idx_q + 1'b1;
      ones_q <= win_end ? '0 : ones_nx;
      fail_q <= fail_nx_o;
    end
  end

  assign fail_q_o = fail_q;
endmodule

// File: rtl/ec_lane.sv
module ec_lane #(
  parameter int STATE_W   = 8,
  parameter int RCT_LIMIT = 8,
  parameter int APT_WIN   = 64,
  parameter int APT_LO    = 16,
  parameter int APT_HI    = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [STATE_W-1:0] osc_i,
  output logic               data_o,
  output logic               pass_o,
  output logic               err_o
);
  logic [STATE_W-1:0] osc_sync;
  logic               bit_q;
  logic               bit_vld_q;
  logic               rct_fail_nx, rct_fail_q;
  logic               apt_fail_nx, apt_fail_q;
  logic               healthy;
  logic               data_q, pass_q;

  ec_sync #(.W(STATE_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (osc_i),
    .sync_o  (osc_sync)
  );

  // Fold the whole sampled state into one bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q     <= 1'b0;
      bit_vld_q <= 1'b0;
    end else begin
      bit_vld_q <= sample_en;
      if (sample_en) bit_q <= ^osc_sync;
    end
  end

  ec_rct #(.LIMIT(RCT_LIMIT)) u_rct (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (bit_vld_q),
    .bit_i     (bit_q),
    .fail_nx_o (rct_fail_nx),
    .fail_q_o  (rct_fail_q)
  );

  ec_apt #(.WIN(APT_WIN), .LO(APT_LO), .HI(APT_HI)) u_apt (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_i     (bit_vld_q),
    .bit_i     (bit_q),
    .fail_nx_o (apt_fail_nx),
    .fail_q_o  (apt_fail_q)
  );

  assign healthy = !(rct_fail_nx || apt_fail_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (bit_vld_q) begin
      data_q <= bit_q & healthy;
      pass_q <= healthy;
    end
  end

  assign data_o = data_q;
  assign pass_o = pass_q;
  assign err_o  = rct_fail_q | apt_fail_q;
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector #(
  parameter int NUM_LANES = 4,
  parameter int STATE_W   = 8,
  parameter int RCT_LIMIT = 8,
  parameter int APT_WIN   = 64,
  parameter int APT_LO    = 16,
  parameter int APT_HI    = 48
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sample_en,
  input  logic [NUM_LANES*STATE_W-1:0]  osc_state,
  output logic                          out_valid,
  output logic [NUM_LANES-1:0]          out_data,
  output logic [NUM_LANES-1:0]          out_mask,
  output logic [NUM_LANES-1:0]          lane_err,
  output logic                          err_any
);
  logic en_d1_q;
  logic valid_q;

  // Valid pipeline matches the lane sample and output register stages.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d1_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      en_d1_q <= sample_en;
      valid_q <= en_d1_q;
    end
  end

  for (genvar li = 0; li < NUM_LANES; li++) begin : g_lane
    ec_lane #(
      .STATE_W   (STATE_W),
      .RCT_LIMIT (RCT_LIMIT),
      .APT_WIN   (APT_WIN),
      .APT_LO    (APT_LO),
      .APT_HI    (APT_HI)
    ) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .osc_i     (osc_state[li*STATE_W +: STATE_W]),
      .data_o    (out_data[li]),
      .pass_o    (out_mask[li]),
      .err_o     (lane_err[li])
    );
  end

  assign out_valid = valid_q;
  assign err_any   = |lane_err;
endmodule

// File: rtl/ec_checker.sv
module ec_checker #(
  parameter int NUM_LANES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sample_en,
  input logic                 out_valid,
  input logic [NUM_LANES-1:0] out_data,
  input logic [NUM_LANES-1:0] out_mask,
  input logic [NUM_LANES-1:0] lane_err
);
  initial begin
    a_r1_lane_count: assert (ec_pkg::lanes_legal(NUM_LANES))
      else $error("lane count %0d not allowed", NUM_LANES);
  end

  // R10: a masked lane never carries a one.
  a_r10_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data & ~out_mask) == '0);

  // R3: every output word comes from a sample enable two cycles earlier.
  a_r3_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(sample_en, 2));

  // R4: outputs hold between words.
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_data) && $stable(out_mask)));

  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(lane_err));

  // R10: a lane flagged in error is masked in the same word.
  a_r10_err_masked: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_mask & lane_err) == '0));

  // R11: reset clears the stream outputs.
  a_r11_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_mask == '0 && lane_err == '0));
endmodule

bind entropy_collector ec_checker #(.NUM_LANES(NUM_LANES)) u_ec_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_mask  (out_mask),
  .lane_err  (lane_err)
);

// File: tb/entropy_collector_test.sv
module entropy_collector_test;
  localparam int NL = 4;
  localparam int SW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sample_en = 1'b0;
  logic [NL*SW-1:0] osc_state = '0;
  logic            out_valid;
  logic [NL-1:0]   out_data, out_mask, lane_err;
  logic            err_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  entropy_collector #(.NUM_LANES(NL), .STATE_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .osc_state(osc_state),
    .out_valid(out_valid), .out_data(out_data), .out_mask(out_mask),
    .lane_err(lane_err), .err_any(err_any)
  );

  // {osc_state, expected data, expected mask}; lane 1 stays at parity 1.
  localparam logic [39:0] VEC [12] = '{
    40'hFFA80701_7_F, 40'h100B8003_E_F, 40'hFF00FE01_3_F, 40'h103C1303_A_F,
    40'hFFA80701_7_F, 40'h100B8003_E_F, 40'hFF00FE01_3_F, 40'h103C1303_8_D,
    40'hFFA80701_5_D, 40'h100B8003_C_D, 40'hFF00FE01_1_D, 40'h103C1303_8_D
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample_en = 1'b0;
    osc_state = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drive a state, let it cross the synchronizer, sample, wait for the word.
  task automatic push(input logic [NL*SW-1:0] v);
    osc_state = v;
    repeat (2) @(negedge clk);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [NL*SW-1:0] uni(input logic b);
    return b ? {NL{8'hE0}} : {NL{8'h81}};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11: reset state
    check("R11 valid", out_valid, 0);
    check("R11 data", out_data, 0);
    check("R11 mask", out_mask, 0);
    check("R11 err", {err_any, lane_err}, 0);

    // R2 R5 R10 R12: table walk
    for (int j = 0; j < 12; j++) begin
      push(VEC[j][39:8]);
      check("R3 valid", out_valid, 1);
      check("R2/R12 data", out_data, VEC[j][7:4]);
      check("R5/R12 mask", out_mask, VEC[j][3:0]);
      check("R5 lane_err", lane_err, ~VEC[j][3:0] & 4'hF);
      check("R10 err_any", err_any, (j >= 7));
    end

    // R6: lane 1 breaks its run and recovers at once
    push(32'hFFA80301);
    check("R6 data", out_data, 4'h5);
    check("R6 mask", out_mask, 4'hF);
    check("R6 err", {err_any, lane_err}, 0);

    // R4: inputs move, no enable, nothing changes
    osc_state = 32'h12345678;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      osc_state = osc_state ^ 32'h0F0F00FF;
      check("R4 no valid", out_valid, 0);
      check("R4 hold", {out_data, out_mask, lane_err}, {4'h5, 4'hF, 4'h0});
    end

    // R3: latency of one sample
    @(negedge clk);
    osc_state = uni(1'b1);
    repeat (2) @(negedge clk);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    check("R3 not yet", out_valid, 0);
    @(negedge clk);
    check("R3 valid", out_valid, 1);
    check("R3 data", out_data, 4'hF);
    @(negedge clk);
    check("R3 one pulse", out_valid, 0);

    // R7 R9: too many ones, then a balanced window
    do_reset();
    for (int k = 0; k < 128; k++) begin
      push(uni((k % 7) != 6 || k >= 64 ? ((k >= 64) ? logic'(k % 2) : 1'b1) : 1'b0));
      if (k == 62) check("R7 mid window", out_mask, 4'hF);
      if (k == 63) begin
        check("R7 high mask", out_mask, 4'h0);
        check("R7 high data", out_data, 4'h0);
        check("R7 high err", {err_any, lane_err}, 5'h1F);
      end
      if (k == 64) check("R9 held", out_mask, 4'h0);
      if (k == 126) check("R9 still held", lane_err, 4'hF);
      if (k == 127) begin
        check("R9 recover mask", out_mask, 4'hF);
        check("R9 recover err", {err_any, lane_err}, 0);
        check("R9 recover data", out_data, 4'hF);
      end
    end

    // R7: too few ones
    do_reset();
    for (int k = 0; k < 64; k++) begin
      push(uni((k % 7) == 6));
      if (k == 62) check("R7 low mid", out_mask, 4'hF);
      if (k == 63) check("R7 low fail", {err_any, lane_err, out_mask}, 9'h1F0);
    end

    // R8: exactly the upper bound passes
    do_reset();
    for (int k = 0; k < 64; k++) begin
      push(uni((k % 4) != 3));
      if (k == 63) begin
        check("R8 bound mask", out_mask, 4'hF);
        check("R8 bound err", {err_any, lane_err}, 0);
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule